// File: doc/BRIEF.md
# PATA PIO cycle sequencer

This block runs a single programmed-I/O transfer on a parallel-ATA drive bus. A host presents one request: a 5-bit target address, a direction, a flag that says whether the target is an 8-bit task-file register or the 16-bit data port, and the word to write. The block then sequences the drive-side pins. The address and chip selects settle first. The read or write strobe is then held low. Last comes a recovery gap before the next access may begin. Read data is returned together with a one-clock completion pulse.

Every phase length is a programmable count of clock ticks. Register and data accesses each have their own active, recovery and whole-cycle values, and they share one setup value. When ready-checking is enabled, a drive that holds IORDY low stretches the strobe. The stretch has a hard bound, and the stretched time counts toward the whole-cycle budget when recovery is worked out. A small side output gives the wait-state code that belongs to the selected PIO mode.

The request side is a valid/ready stream. `req_ready` is high only while the sequencer is idle, and a request moves on the clock edge where both `req_valid` and `req_ready` are high. The host may hold `req_valid` high for as long as it likes. The completion side has no back-pressure: `rsp_valid` is a pulse, and the host must take `rsp_rdata` in that cycle.

Top module: `pio_cycle_seq`

## Requirements
- R1: After reset, and whenever idle, `ata_cs0_n` = 1, `ata_cs1_n` = 1, `ata_da` = 0, both strobes are 1, `ata_dd_oe` = 0, `req_ready` = 1 and `rsp_valid` = 0.
- R2: A request is taken only while `req_ready` is 1. `req_ready` stays 0 from the accepting edge through the completion pulse and returns to 1 in the cycle after the pulse.
- R3: Address bit 0 drives `ata_cs0_n`, bit 1 drives `ata_cs1_n`, and bits 4:2 drive `ata_da`. These values stay constant from the first setup cycle to the last recovery cycle. Task-file register k is addressed as (k<<2)|2, and the control/alternate-status register as (6<<2)|1.
- R4: After the accepting edge, the strobe stays high for max(`cfg_setup`,1) cycles and then goes low.
- R5: A read (`req_write` = 0) pulls only `ata_dior_n` low. `rsp_rdata` holds the `ata_dd_in` value captured on the edge where `ata_dior_n` returns high.
- R6: A write (`req_write` = 1) pulls only `ata_diow_n` low. `ata_dd_out` carries the write word and `ata_dd_oe` = 1 from the first setup cycle onward, so data is on the bus before and during the strobe.
- R7: With no ready-stretch, the strobe is low for max(A,1) cycles. A is `cfg_reg_act` when `req_is_reg` = 1 and `cfg_dat_act` otherwise.
- R8: Let An = max(A,1) and cap = IORDY_LIMIT − An when An < IORDY_LIMIT, else 0 (the default limit is 51). If `cfg_iordy_en` = 1 and `ata_iordy` = 0 at the end of An, the strobe stays low until a clock edge sees `ata_iordy` = 1, for at most cap extra cycles. When `cfg_iordy_en` = 0, `ata_iordy` has no effect.
- R9: Let E be the total number of strobe-low cycles, and C and V the selected cycle and recovery values. The strobe then stays high for max(C−E,1) cycles when C > E and C−E > V. Otherwise it stays high for max(V,1) cycles. After that comes the completion pulse.
- R10: `rsp_valid` is high for exactly one cycle per accepted request.
- R11: `wait_state` is 3 for `cfg_pio_mode` 0, 2 for modes 1 and 2, and 1 for modes 3 and above.
- R12: The two strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of every timing count |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 5 | {DA[2:0], CS1N, CS0N} image of the target |
| req_write | input | 1 | 1 = write, 0 = read |
| req_is_reg | input | 1 | 1 = 8-bit register timing, 0 = 16-bit data timing |
| req_wdata | input | DW | Write word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Captured read word |
| cfg_setup | input | TW | Setup ticks (both kinds) |
| cfg_reg_act | input | TW | Register active ticks |
| cfg_reg_rec | input | TW | Register minimum recovery ticks |
| cfg_reg_cyc | input | TW | Register whole-cycle ticks |
| cfg_dat_act | input | TW | Data active ticks |
| cfg_dat_rec | input | TW | Data minimum recovery ticks |
| cfg_dat_cyc | input | TW | Data whole-cycle ticks |
| cfg_iordy_en | input | 1 | Enable ready-stretch |
| cfg_pio_mode | input | 3 | PIO mode number for the wait-state code |
| wait_state | output | 2 | Wait-state code for the mode |
| ata_cs0_n | output | 1 | Command-block select, active low |
| ata_cs1_n | output | 1 | Control-block select, active low |
| ata_da | output | 3 | Register address lines |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | DW | Data bus, outbound |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_in | input | DW | Data bus, inbound |
| ata_iordy | input | 1 | Drive ready |

## Verification
The sequencer is exercised with register and data accesses in both directions. Their timing sets are chosen so that recovery comes once from the whole-cycle remainder and once from the minimum-recovery floor, which shows which timing set and which branch of the recovery rule were used. Zero counts test the one-cycle floor on every phase. Four ready patterns are tried: ready already high, held low until the cap, released three cycles into the stretch, and held low with checking disabled. An active count above the limit must produce no stretch at all. Changing the inbound bus right after the read strobe rises shows whether read data is captured on the release edge or later.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

  // Width of the address image: {da[2:0], cs1_n, cs0_n}
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_WAIT,
    ST_RECOVER,
    ST_DONE
  } pio_state_e;

  // Wait-state code per PIO mode number
  function automatic logic [1:0] mode_wait_code(input logic [2:0] mode);
    logic [1:0] code;
    case (mode)
      3'd0:       code = 2'd3;
      3'd1, 3'd2: code = 2'd2;
      default:    code = 2'd1;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/pio_phase_timer.sv
// Counts clocks inside one phase; last is high in the final cycle.
// A target of zero behaves as one.
module pio_phase_timer #(
  parameter int EW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [EW-1:0] target,
  output logic          last
);

  logic [EW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = ({1'b0, cnt_q} + {{EW{1'b0}}, 1'b1}) >= {1'b0, target};

endmodule

// File: rtl/pio_timing_sel.sv
// Picks the register or data timing set and derives the
// effective active length, the stretch cap and the recovery target.
module pio_timing_sel #(
  parameter int TW          = 8,
  parameter int CW          = 6,
  parameter int EW          = 9,
  parameter int IORDY_LIMIT = 51
) (
  input  logic          is_reg,
  input  logic [TW-1:0] cfg_reg_act,
  input  logic [TW-1:0] cfg_reg_rec,
  input  logic [TW-1:0] cfg_reg_cyc,
  input  logic [TW-1:0] cfg_dat_act,
  input  logic [TW-1:0] cfg_dat_rec,
  input  logic [TW-1:0] cfg_dat_cyc,
  input  logic [CW-1:0] ext_ticks,
  output logic [EW-1:0] act_n,
  output logic [CW-1:0] stretch_cap,
  output logic [EW-1:0] rec_target
);

  localparam logic [EW-1:0] LIM_E = EW'(IORDY_LIMIT);

  logic [EW-1:0] act_e, rec_e, cyc_e, eff_e, rem_e, cap_e;

  always_comb begin
    act_e = is_reg ? EW'(cfg_reg_act) : EW'(cfg_dat_act);
    rec_e = is_reg ? EW'(cfg_reg_rec) : EW'(cfg_dat_rec);
    cyc_e = is_reg ? EW'(cfg_reg_cyc) : EW'(cfg_dat_cyc);

    act_n = (act_e == '0) ? EW'(1) : act_e;

    cap_e       = (act_n < LIM_E) ? (LIM_E - act_n) : '0;
    stretch_cap = CW'(cap_e);

    eff_e = act_n + EW'(ext_ticks);
    rem_e = cyc_e - eff_e;
    if ((cyc_e > eff_e) && (rem_e > rec_e)) begin
      rec_target = rem_e;
    end else begin
      rec_target = rec_e;
    end
  end

endmodule

// File: rtl/pio_pin_drv.sv
// Registers every drive-side pin so that the pins change together
// on the edge where the sequencer changes phase.
module pio_pin_drv
  import pio_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DW-1:0]     wdata_in,
  input  logic              write_in,
  input  logic              bus_hold,
  input  logic              rd_low,
  input  logic              wr_low,
  output logic              cs0_n,
  output logic              cs1_n,
  output logic [2:0]        da,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DW-1:0]     dd_out,
  output logic              dd_oe
);

  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     data_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_nx;
  logic [DW-1:0]     data_nx;
  logic              write_nx;

  assign addr_nx  = load ? addr_in  : addr_q;
  assign data_nx  = load ? wdata_in : data_q;
  assign write_nx = load ? write_in : write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      write_q <= 1'b0;
      cs0_n   <= 1'b1;
      cs1_n   <= 1'b1;
      da      <= '0;
      dior_n  <= 1'b1;
      diow_n  <= 1'b1;
      dd_out  <= '0;
      dd_oe   <= 1'b0;
    end else begin
      addr_q  <= addr_nx;
      data_q  <= data_nx;
      write_q <= write_nx;
      if (bus_hold) begin
        cs0_n <= addr_nx[0];
        cs1_n <= addr_nx[1];
        da    <= addr_nx[4:2];
      end else begin
        cs0_n <= 1'b1;
        cs1_n <= 1'b1;
        da    <= '0;
      end
      dior_n <= ~rd_low;
      diow_n <= ~wr_low;
      dd_oe  <= bus_hold & write_nx;
      dd_out <= (bus_hold & write_nx) ? data_nx : '0;
    end
  end

endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
  import pio_seq_pkg::*;
#(
  parameter int TW          = 8,
  parameter int DW          = 16,
  parameter int IORDY_LIMIT = 51
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_is_reg,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [TW-1:0]     cfg_setup,
  input  logic [TW-1:0]     cfg_reg_act,
  input  logic [TW-1:0]     cfg_reg_rec,
  input  logic [TW-1:0]     cfg_reg_cyc,
  input  logic [TW-1:0]     cfg_dat_act,
  input  logic [TW-1:0]     cfg_dat_rec,
  input  logic [TW-1:0]     cfg_dat_cyc,
  input  logic              cfg_iordy_en,
  input  logic [2:0]        cfg_pio_mode,
  output logic [1:0]        wait_state,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic [2:0]        ata_da,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  output logic [DW-1:0]     ata_dd_out,
  output logic              ata_dd_oe,
  input  logic [DW-1:0]     ata_dd_in,
  input  logic              ata_iordy
);

  localparam int CW = $clog2(IORDY_LIMIT + 1);
  localparam int EW = ((TW > CW) ? TW : CW) + 1;

  pio_state_e    state_q, state_d;
  logic          is_reg_q, write_q;
  logic [CW-1:0] ext_q;
  logic [DW-1:0] rdata_q;
  logic [EW-1:0] act_n, rec_target, phase_target;
  logic [CW-1:0] stretch_cap;
  logic          phase_last, accept, ext_full, strobe_release;
  logic          bus_hold, strobe_low, write_nx;

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign ext_full = ({1'b0, ext_q} + {{CW{1'b0}}, 1'b1}) >= {1'b0, stretch_cap};

  pio_timing_sel #(
    .TW(TW), .CW(CW), .EW(EW), .IORDY_LIMIT(IORDY_LIMIT)
  ) u_tsel (
    .is_reg      (is_reg_q),
    .cfg_reg_act (cfg_reg_act),
    .cfg_reg_rec (cfg_reg_rec),
    .cfg_reg_cyc (cfg_reg_cyc),
    .cfg_dat_act (cfg_dat_act),
    .cfg_dat_rec (cfg_dat_rec),
    .cfg_dat_cyc (cfg_dat_cyc),
    .ext_ticks   (ext_q),
    .act_n       (act_n),
    .stretch_cap (stretch_cap),
    .rec_target  (rec_target)
  );

  // Next-phase decision
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (accept) state_d = ST_SETUP;
      ST_SETUP:   if (phase_last) state_d = ST_ACTIVE;
      ST_ACTIVE: begin
        if (phase_last) begin
          if (cfg_iordy_en && !ata_iordy && (stretch_cap != '0)) begin
            state_d = ST_WAIT;
          end else begin
            state_d = ST_RECOVER;
          end
        end
      end
      ST_WAIT:    if (ata_iordy || ext_full) state_d = ST_RECOVER;
      ST_RECOVER: if (phase_last) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_SETUP:   phase_target = EW'(cfg_setup);
      ST_ACTIVE:  phase_target = act_n;
      ST_RECOVER: phase_target = rec_target;
      default:    phase_target = '0;
    endcase
  end

  pio_phase_timer #(.EW(EW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (state_d != state_q),
    .target (phase_target),
    .last   (phase_last)
  );

  assign strobe_release = ((state_q == ST_ACTIVE) || (state_q == ST_WAIT)) &&
                          (state_d == ST_RECOVER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      is_reg_q <= 1'b0;
      write_q  <= 1'b0;
      ext_q    <= '0;
      rdata_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        is_reg_q <= req_is_reg;
        write_q  <= req_write;
        ext_q    <= '0;
      end else if (state_q == ST_WAIT) begin
        ext_q <= ext_q + 1'b1;
      end
      if (strobe_release && !write_q) begin
        rdata_q <= ata_dd_in;
      end
    end
  end

  assign bus_hold   = (state_d == ST_SETUP) || (state_d == ST_ACTIVE) ||
                      (state_d == ST_WAIT)  || (state_d == ST_RECOVER);
  assign strobe_low = (state_d == ST_ACTIVE) || (state_d == ST_WAIT);
  assign write_nx   = accept ? req_write : write_q;

  pio_pin_drv #(.DW(DW)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .write_in (req_write),
    .bus_hold (bus_hold),
    .rd_low   (strobe_low && !write_nx),
    .wr_low   (strobe_low && write_nx),
    .cs0_n    (ata_cs0_n),
    .cs1_n    (ata_cs1_n),
    .da       (ata_da),
    .dior_n   (ata_dior_n),
    .diow_n   (ata_diow_n),
    .dd_out   (ata_dd_out),
    .dd_oe    (ata_dd_oe)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = (state_q == ST_DONE);
  assign rsp_rdata  = rdata_q;
  assign wait_state = mode_wait_code(cfg_pio_mode);

endmodule

// File: rtl/pio_cycle_seq_chk.sv
module pio_cycle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       ata_dior_n,
  input logic       ata_diow_n,
  input logic       ata_dd_oe,
  input logic       ata_cs0_n,
  input logic       ata_cs1_n,
  input logic [2:0] ata_da
);

  logic strobe_any;
  assign strobe_any = !ata_dior_n || !ata_diow_n;

  assert_strobes_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n));

  assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ata_dior_n && ata_diow_n && ata_cs0_n && ata_cs1_n));

  assert_ready_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_write_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_diow_n |-> ata_dd_oe);

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_any && $past(strobe_any)) |-> $stable({ata_cs1_n, ata_cs0_n, ata_da}));

  assert_setup_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ata_dior_n) || $fell(ata_diow_n)) |-> !$past(req_ready));

endmodule

bind pio_cycle_seq pio_cycle_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .ata_dior_n (ata_dior_n),
  .ata_diow_n (ata_diow_n),
  .ata_dd_oe  (ata_dd_oe),
  .ata_cs0_n  (ata_cs0_n),
  .ata_cs1_n  (ata_cs1_n),
  .ata_da     (ata_da)
);

// File: tb/pio_cycle_seq_tb.sv
`timescale 1ns/1ps
module pio_cycle_seq_tb;

  localparam int LIMIT = 51;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_is_reg = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [7:0]  cfg_setup = 8'd2;
  logic [7:0]  cfg_reg_act = 8'd5, cfg_reg_rec = 8'd3, cfg_reg_cyc = 8'd12;
  logic [7:0]  cfg_dat_act = 8'd3, cfg_dat_rec = 8'd4, cfg_dat_cyc = 8'd6;
  logic        cfg_iordy_en = 1'b0;
  logic [2:0]  cfg_pio_mode = '0;
  logic [1:0]  wait_state;
  logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe;
  logic [2:0]  ata_da;
  logic [15:0] ata_dd_out;
  logic [15:0] ata_dd_in = '0;
  logic        ata_iordy = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pio_cycle_seq u_dut (.*);

  typedef struct {
    logic [4:0]  addr;
    logic        wr;
    logic [15:0] data;
    int          setup;
    int          act;
    int          rec;
  } exp_t;

  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  function automatic int floor1(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  // Driver: computes the expected timing from the requirements and runs one access.
  // iordy_mode: 0 = ready high, 1 = held low, 2 = released after m strobe-low cycles
  task automatic run_cycle(input logic [4:0] addr, input logic wr, input logic is_reg,
                           input logic [15:0] data, input int iordy_mode, input int m);
    exp_t e;
    int a, cap, ext, eff, cyc, rec;
    a   = floor1(is_reg ? int'(cfg_reg_act) : int'(cfg_dat_act));
    cyc = is_reg ? int'(cfg_reg_cyc) : int'(cfg_dat_cyc);
    rec = is_reg ? int'(cfg_reg_rec) : int'(cfg_dat_rec);
    cap = (a < LIMIT) ? LIMIT - a : 0;
    ext = 0;
    if (cfg_iordy_en && iordy_mode == 1) ext = cap;
    if (cfg_iordy_en && iordy_mode == 2 && m > a) ext = (m - a < cap) ? m - a : cap;
    eff = a + ext;
    e.addr  = addr;
    e.wr    = wr;
    e.data  = data;
    e.setup = floor1(int'(cfg_setup));
    e.act   = eff;
    e.rec   = floor1(((cyc > eff) && (cyc - eff > rec)) ? cyc - eff : rec);
    exp_q.push_back(e);

    @(negedge clk);
    ata_iordy  = (iordy_mode == 0);
    ata_dd_in  = wr ? 16'h0000 : data;
    req_addr   = addr;
    req_write  = wr;
    req_is_reg = is_reg;
    req_wdata  = wr ? data : 16'h0000;
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid  = 1'b0;
    req_wdata  = 16'hDEAD;
    while (ata_dior_n && ata_diow_n) @(negedge clk);
    if (iordy_mode == 2) begin
      for (int i = 1; i < m; i++) @(negedge clk);
      ata_iordy = 1'b1;
    end
    while (!(ata_dior_n && ata_diow_n)) @(negedge clk);
    ata_dd_in = ~ata_dd_in;  // a late capture would pick this up
    while (!rsp_valid) @(negedge clk);
    ata_iordy = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: measures each access at the pins and compares with the queue head
  int          ph = 0;
  int          cnt = 0;
  int          o_setup = 0, o_act = 0;
  logic [4:0]  o_addr;
  logic        o_wr;
  logic [15:0] o_wdata;
  logic        o_oe;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      case (ph)
        0: if (req_valid && req_ready) begin ph = 1; cnt = 0; end
        1: begin
          if (cnt == 0) chk(req_ready == 1'b0, "R2", "ready while busy", req_ready, 0);
          if (ata_dior_n && ata_diow_n) begin
            cnt++;
          end else begin
            o_setup = cnt;
            o_addr  = {ata_da, ata_cs1_n, ata_cs0_n};
            o_wr    = !ata_diow_n;
            o_wdata = ata_dd_out;
            o_oe    = ata_dd_oe;
            chk(ata_dior_n || ata_diow_n, "R12", "both strobes low", 0, 1);
            ph = 2;
            cnt = 1;
          end
        end
        2: begin
          if (!ata_dior_n || !ata_diow_n) begin
            cnt++;
          end else begin
            o_act = cnt;
            ph = 3;
            cnt = 1;
          end
        end
        3: begin
          if (!rsp_valid) begin
            cnt++;
          end else begin
            exp_t e;
            if (exp_q.size() == 0) begin
              chk(1'b0, "R10", "unexpected completion", 1, 0);
            end else begin
              e = exp_q.pop_front();
              chk(o_setup == e.setup, "R4", "setup cycles", o_setup, e.setup);
              chk(o_act == e.act, "R7 and R8", "strobe-low cycles", o_act, e.act);
              chk(cnt == e.rec, "R9", "recovery cycles", cnt, e.rec);
              chk(o_addr == e.addr, "R3", "address pins", o_addr, e.addr);
              chk(o_wr == e.wr, "R5 and R6", "strobe choice", o_wr, e.wr);
              if (e.wr) begin
                chk(o_oe && o_wdata == e.data, "R6", "write data on bus", o_wdata, e.data);
              end else begin
                chk(rsp_rdata == e.data, "R5", "read data", rsp_rdata, e.data);
              end
            end
            ph = 4;
          end
        end
        4: begin
          chk(!rsp_valid && req_ready, "R10", "pulse width / ready return",
              {rsp_valid, req_ready}, 2'b01);
          ph = 0;
        end
        default: ph = 0;
      endcase
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset levels
    chk({ata_cs0_n, ata_cs1_n, ata_da, ata_dior_n, ata_diow_n, ata_dd_oe, req_ready, rsp_valid}
        == 10'b11_000_11_0_1_0, "R1", "reset pin levels",
        {ata_cs0_n, ata_cs1_n, ata_da, ata_dior_n, ata_diow_n, ata_dd_oe, req_ready, rsp_valid},
        10'b11_000_11_0_1_0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && ata_dior_n && ata_diow_n, "R1", "idle after reset", req_ready, 1);

    // Register read of status (7<<2)|2: recovery from cycle remainder 12-5=7
    run_cycle(5'b11110, 1'b0, 1'b1, 16'h0050, 0, 0);
    // Register write to control (6<<2)|1
    run_cycle(5'b11001, 1'b1, 1'b1, 16'h0004, 0, 0);
    // Data read (0<<2)|2: remainder 3 not above 4, floor used
    run_cycle(5'b00010, 1'b0, 1'b0, 16'hA55A, 0, 0);
    // Data write
    run_cycle(5'b00010, 1'b1, 1'b0, 16'hBEEF, 0, 0);

    // Zero counts: every phase floors to one cycle
    cfg_setup = 8'd0; cfg_dat_act = 8'd0; cfg_dat_rec = 8'd0; cfg_dat_cyc = 8'd0;
    run_cycle(5'b01010, 1'b1, 1'b0, 16'h1234, 0, 0);
    run_cycle(5'b01110, 1'b0, 1'b0, 16'h4321, 0, 0);
    cfg_setup = 8'd2; cfg_dat_act = 8'd3; cfg_dat_rec = 8'd4; cfg_dat_cyc = 8'd6;

    // R8: ready checking
    cfg_iordy_en = 1'b1;
    run_cycle(5'b11110, 1'b0, 1'b1, 16'h00D0, 0, 0);  // ready high: no stretch
    run_cycle(5'b11110, 1'b0, 1'b1, 16'h0058, 1, 0);  // held low: capped at 51 total
    run_cycle(5'b10110, 1'b1, 1'b1, 16'h00E0, 2, 8);  // released at 8: 3 extra, rec 4
    cfg_dat_act = 8'd60; cfg_dat_cyc = 8'd70;
    run_cycle(5'b00010, 1'b0, 1'b0, 16'h7E7E, 1, 0);  // active beyond limit: cap 0
    cfg_dat_act = 8'd3; cfg_dat_cyc = 8'd6;
    cfg_iordy_en = 1'b0;
    run_cycle(5'b11110, 1'b0, 1'b1, 16'h0041, 1, 0);  // disabled: R8 iordy ignored

    // R11: wait-state code per mode
    for (int md = 0; md < 8; md++) begin
      logic [1:0] exp_ws;
      cfg_pio_mode = 3'(md);
      exp_ws = (md == 0) ? 2'd3 : (md < 3) ? 2'd2 : 2'd1;
      @(negedge clk);
      chk(wait_state == exp_ws, "R11", "wait-state code", wait_state, exp_ws);
    end

    chk(exp_q.size() == 0, "R10", "completions outstanding", exp_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule